// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the software-visible register file of a multichannel DMA controller. It serves up to eight channel engines. A processor-side port with a write strobe, an address and 32-bit data sets each channel's transfer mode and direction, enables its interrupt and starts it. The block sends mode, direction, start and abort signals to each engine. It gathers completion events, error events and a live 2-bit state from each engine, and it presents them in one status word. The data-moving engines, descriptor storage and bus mastering sit outside the block.

Reads are combinational: `rdData` reflects the word at `addr` in the same cycle. Writes take effect at the rising clock edge while `wrEn` is high. A start request becomes a one-cycle pulse to the engine, and it is only honoured while that engine reports idle. Interrupt and error flags are sticky until software writes ones back to them. The single `irq` output merges every enabled channel interrupt.

Top module: `dmac_csr`

## Requirements
- R1: The mode word at offset 0x00 gives channel c a 4-bit field at bits 4c+3:4c. Bits 1:0 of the field hold the mode (0 off, 1 scatter-gather, 2 single-shot, 3 stored as written). Bit 2 is the direction (1 memory to device, 0 device to memory). Bit 3 reads as zero. `chMode[2c+1:2c]` and `chDir[c]` follow the stored field from the cycle after the write.
- R2: The word at offset 0x04 is a plain 32-bit read/write register.
- R3: At offset 0x08, bits 7:0 are read/write interrupt enables, one per channel. Writing 1 to bit 8+c raises `chStart[c]` for exactly the one cycle after the write. The start bits always read as zero.
- R4: A start request for channel c is ignored unless `engState[2c+1:2c]` is 0 (idle) in the cycle of the write. The state codes are 0 idle, 1 descriptor fetch, 2 wait and 3 transfer.
- R5: Any write to offset 0x00 whose field for channel c holds mode 0 raises `chAbort[c]` for the one cycle after the write. A write with a non-zero mode raises no abort.
- R6: In the status word at offset 0x10, bit c is the interrupt flag of channel c, which `evDone[c]` or `evErr[c]` sets. Bit 8+c is the error flag, which `evErr[c]` sets. Bits 16+2c+1:16+2c show `engState` for channel c live. An event wins over a clear in the same cycle.
- R7: Writing to offset 0x10 clears exactly those flag bits that are 1 in the written value. Zero bits and the state bits have no effect.
- R8: `irq` is high when any channel has both its interrupt flag and its enable bit set. It follows the flags from the cycle after the event or write that changes them.
- R9: Offsets 0x0C, 0x18 and 0x1C, and every other unused offset, read as zero. Writes to them change no register.
- R10: After reset all registers read as zero, and `chStart`, `chAbort` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for `addr` |
| chMode | output | 2*NUM_CH | Mode per channel |
| chDir | output | NUM_CH | Direction per channel, 1 = memory to device |
| chStart | output | NUM_CH | One-cycle start pulse per channel |
| chAbort | output | NUM_CH | One-cycle abort pulse per channel |
| evDone | input | NUM_CH | Completion event per channel |
| evErr | input | NUM_CH | Error event per channel |
| engState | input | 2*NUM_CH | Live engine state per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The bench issues a start to busy engines mixed with idle ones. A design that ignored the engine state would pulse the busy channels. It also lands a status clear in the same cycle as a completion event. A design that let the clear win would lose the interrupt for good. Further cases rewrite only some mode fields, so that a design that aborted every channel or dropped bit 3 incorrectly shows the wrong abort mask or readback. Other cases write ones to the status state bits and to reserved offsets, where any side effect on the stored words or on `irq` is visible on readback.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;

  localparam logic [4:0] OFF_MODE = 5'h00;
  localparam logic [4:0] OFF_AUX  = 5'h04;
  localparam logic [4:0] OFF_CTL  = 5'h08;
  localparam logic [4:0] OFF_STS  = 5'h10;

  localparam int FIELD_W   = 4;
  localparam int START_LSB = 8;
  localparam int ERR_LSB   = 8;
  localparam int STATE_LSB = 16;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_WAIT  = 2'd2,
    ENG_XFER  = 2'd3
  } engState_e;

  typedef struct packed {
    logic wrMode;
    logic wrAux;
    logic wrCtl;
    logic clrSts;
  } csrStrobe_t;

endpackage

// File: rtl/dmac_csr_ctrl.sv
module dmac_csr_ctrl
  import dmac_csr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_CH-1:0]     startBits,
  input  logic [2*NUM_CH-1:0]   newModes,
  input  logic [2*NUM_CH-1:0]   engState,
  output csrStrobe_t            strb,
  output logic [NUM_CH-1:0]     chStart,
  output logic [NUM_CH-1:0]     chAbort
);

  logic [NUM_CH-1:0] startReq;
  logic [NUM_CH-1:0] abortReq;

  always_comb begin
    strb.wrMode = wrEn && (addr == ADDR_W'(OFF_MODE));
    strb.wrAux  = wrEn && (addr == ADDR_W'(OFF_AUX));
    strb.wrCtl  = wrEn && (addr == ADDR_W'(OFF_CTL));
    strb.clrSts = wrEn && (addr == ADDR_W'(OFF_STS));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_req
    // start honoured only for an idle engine
    assign startReq[c] = strb.wrCtl && startBits[c] &&
                         (engState[2*c +: 2] == ENG_IDLE);
    assign abortReq[c] = strb.wrMode && (newModes[2*c +: 2] == 2'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chStart <= '0;
      chAbort <= '0;
    end else begin
      chStart <= startReq;
      chAbort <= abortReq;
    end
  end

endmodule

// File: rtl/dmac_csr_data.sv
module dmac_csr_data
  import dmac_csr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  csrStrobe_t            strb,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_CH-1:0]     evDone,
  input  logic [NUM_CH-1:0]     evErr,
  input  logic [2*NUM_CH-1:0]   engState,
  output logic [DATA_W-1:0]     rdData,
  output logic [2*NUM_CH-1:0]   chMode,
  output logic [NUM_CH-1:0]     chDir,
  output logic                  irq
);

  logic [NUM_CH-1:0][1:0] modeQ;
  logic [NUM_CH-1:0]      dirQ;
  logic [DATA_W-1:0]      auxQ;
  logic [NUM_CH-1:0]      enQ;
  logic [NUM_CH-1:0]      intQ;
  logic [NUM_CH-1:0]      errQ;

  logic [DATA_W-1:0] modeWord;
  logic [DATA_W-1:0] ctlWord;
  logic [DATA_W-1:0] stsWord;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ[c] <= 2'd0;
        dirQ[c]  <= 1'b0;
      end else if (strb.wrMode) begin
        modeQ[c] <= wrData[FIELD_W*c +: 2];
        dirQ[c]  <= wrData[FIELD_W*c + 2];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        intQ[c] <= 1'b0;
      end else if (evDone[c] || evErr[c]) begin
        intQ[c] <= 1'b1;
      end else if (strb.clrSts && wrData[c]) begin
        intQ[c] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        errQ[c] <= 1'b0;
      end else if (evErr[c]) begin
        errQ[c] <= 1'b1;
      end else if (strb.clrSts && wrData[ERR_LSB + c]) begin
        errQ[c] <= 1'b0;
      end
    end

    assign chMode[2*c +: 2] = modeQ[c];
    assign chDir[c]         = dirQ[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      auxQ <= '0;
      enQ  <= '0;
    end else begin
      if (strb.wrAux) auxQ <= wrData;
      if (strb.wrCtl) enQ  <= wrData[NUM_CH-1:0];
    end
  end

  always_comb begin
    modeWord = '0;
    ctlWord  = '0;
    stsWord  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      modeWord[FIELD_W*c +: FIELD_W] = {1'b0, dirQ[c], modeQ[c]};
      stsWord[c]                     = intQ[c];
      stsWord[ERR_LSB + c]           = errQ[c];
      stsWord[STATE_LSB + 2*c +: 2]  = engState[2*c +: 2];
    end
    ctlWord[NUM_CH-1:0] = enQ;
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFF_MODE): rdData = modeWord;
      ADDR_W'(OFF_AUX):  rdData = auxQ;
      ADDR_W'(OFF_CTL):  rdData = ctlWord;
      ADDR_W'(OFF_STS):  rdData = stsWord;
      default:           rdData = '0;
    endcase
  end

  assign irq = |(intQ & enQ);

endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
  import dmac_csr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic [2*NUM_CH-1:0]   chMode,
  output logic [NUM_CH-1:0]     chDir,
  output logic [NUM_CH-1:0]     chStart,
  output logic [NUM_CH-1:0]     chAbort,
  input  logic [NUM_CH-1:0]     evDone,
  input  logic [NUM_CH-1:0]     evErr,
  input  logic [2*NUM_CH-1:0]   engState,
  output logic                  irq
);

  csrStrobe_t          strb;
  logic [2*NUM_CH-1:0] newModes;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fld
    assign newModes[2*c +: 2] = wrData[FIELD_W*c +: 2];
  end

  dmac_csr_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .startBits (wrData[START_LSB +: NUM_CH]),
    .newModes  (newModes),
    .engState  (engState),
    .strb      (strb),
    .chStart   (chStart),
    .chAbort   (chAbort)
  );

  dmac_csr_data #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .wrData   (wrData),
    .evDone   (evDone),
    .evErr    (evErr),
    .engState (engState),
    .rdData   (rdData),
    .chMode   (chMode),
    .chDir    (chDir),
    .irq      (irq)
  );

endmodule

// File: rtl/dmac_csr_chk.sv
module dmac_csr_chk
  import dmac_csr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     addr,
  input logic [DATA_W-1:0]     wrData,
  input logic [DATA_W-1:0]     rdData,
  input logic [2*NUM_CH-1:0]   chMode,
  input logic [NUM_CH-1:0]     chDir,
  input logic [NUM_CH-1:0]     chStart,
  input logic [NUM_CH-1:0]     chAbort,
  input logic [NUM_CH-1:0]     evDone,
  input logic [NUM_CH-1:0]     evErr,
  input logic [2*NUM_CH-1:0]   engState,
  input logic                  irq
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_mode_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == ADDR_W'(OFF_MODE)) |=>
        (chMode[2*c +: 2] == $past(wrData[FIELD_W*c +: 2]) &&
         chDir[c] == $past(wrData[FIELD_W*c + 2])));

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
      chStart[c] |=> !chStart[c]);

    p_start_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
      chStart[c] |-> $past(wrEn && addr == ADDR_W'(OFF_CTL) &&
                           wrData[START_LSB + c] &&
                           engState[2*c +: 2] == ENG_IDLE));

    p_abort_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
      chAbort[c] |-> $past(wrEn && addr == ADDR_W'(OFF_MODE) &&
                           wrData[FIELD_W*c +: 2] == 2'd0));
  end

  p_state_live_r6: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(OFF_STS)) |->
      rdData[STATE_LSB +: 2*NUM_CH] == engState);

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past((|evDone) || (|evErr) ||
                         (wrEn && addr == ADDR_W'(OFF_CTL))));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(5'h0C) || addr == ADDR_W'(5'h18) ||
     addr == ADDR_W'(5'h1C)) |-> rdData == '0);

endmodule

bind dmac_csr dmac_csr_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .rdData   (rdData),
  .chMode   (chMode),
  .chDir    (chDir),
  .chStart  (chStart),
  .chAbort  (chAbort),
  .evDone   (evDone),
  .evErr    (evErr),
  .engState (engState),
  .irq      (irq)
);

// File: tb/dmac_csr_bench.sv
module dmac_csr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                wrEn = 1'b0;
  logic [ADDR_W-1:0]   addr = '0;
  logic [DATA_W-1:0]   wrData = '0;
  logic [DATA_W-1:0]   rdData;
  logic [2*NUM_CH-1:0] chMode;
  logic [NUM_CH-1:0]   chDir;
  logic [NUM_CH-1:0]   chStart;
  logic [NUM_CH-1:0]   chAbort;
  logic [NUM_CH-1:0]   evDone = '0;
  logic [NUM_CH-1:0]   evErr = '0;
  logic [2*NUM_CH-1:0] engState = '0;
  logic                irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_csr #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dmac_csr (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chMode(chMode), .chDir(chDir), .chStart(chStart),
    .chAbort(chAbort), .evDone(evDone), .evErr(evErr), .engState(engState),
    .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic pulseEv(logic [7:0] done, logic [7:0] err);
    @(negedge clk);
    evDone = done; evErr = err;
    @(negedge clk);
    evDone = '0; evErr = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h00, v); check("R10 mode word", v, 32'h0);
    rd(5'h04, v); check("R10 aux word", v, 32'h0);
    rd(5'h08, v); check("R10 ctl word", v, 32'h0);
    rd(5'h10, v); check("R10 status word", v, 32'h0);
    check("R10 pulses low", {chStart, chAbort}, 32'h0);
    check("R10 irq low", irq, 1'b0);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    wr(5'h00, 32'hFFFF_FFFF);
    check("R5 no abort for mode 3", chAbort, 8'h00);
    rd(5'h00, v); check("R1 bit3 reads zero", v, 32'h7777_7777);
    check("R1 chMode all 3", chMode, 16'hFFFF);
    check("R1 chDir all 1", chDir, 8'hFF);
    // ch0 single-shot mem-to-dev, ch1 scatter-gather dev-to-mem, rest off
    wr(5'h00, 32'h0000_0016);
    check("R5 abort mask", chAbort, 8'hFC);
    @(negedge clk);
    check("R5 abort one cycle", chAbort, 8'h00);
    rd(5'h00, v); check("R1 mode readback", v, 32'h0000_0016);
    check("R1 chMode fields", chMode, 16'h0006);
    check("R1 chDir field", chDir, 8'h01);
  endtask

  task automatic t_aux();
    logic [31:0] v;
    wr(5'h04, 32'hA5C3_0F1E);
    rd(5'h04, v); check("R2 aux readback", v, 32'hA5C3_0F1E);
  endtask

  task automatic t_start();
    logic [31:0] v;
    engState = '0;
    wr(5'h08, 32'h0000_0503);
    check("R3 start pulse", chStart, 8'h05);
    @(negedge clk);
    check("R3 start self-clears", chStart, 8'h00);
    rd(5'h08, v); check("R3 start bits read zero", v, 32'h0000_0003);
  endtask

  task automatic t_busy();
    engState = 16'h00C8; // ch1 wait, ch3 transfer
    wr(5'h08, 32'h0000_0F03);
    check("R4 busy channels ignored", chStart, 8'h05);
    engState = '0;
  endtask

  task automatic t_status();
    logic [31:0] v;
    engState = 16'h1B2D;
    pulseEv(8'h01, 8'h04);
    rd(5'h10, v); check("R6 status flags and state", v, 32'h1B2D_0405);
    wr(5'h10, 32'hFFFF_0401);
    rd(5'h10, v); check("R7 partial clear", v, 32'h1B2D_0004);
    wr(5'h10, 32'h0000_0004);
    rd(5'h10, v); check("R7 final clear", v, 32'h1B2D_0000);
    engState = '0;
  endtask

  task automatic t_irq();
    logic [31:0] v;
    pulseEv(8'h20, 8'h00);
    check("R8 irq masked", irq, 1'b0);
    wr(5'h08, 32'h0000_0020);
    check("R8 irq enabled", irq, 1'b1);
    wr(5'h10, 32'h0000_0020);
    check("R8 irq cleared", irq, 1'b0);
    rd(5'h10, v); check("R7 clear via irq path", v, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    @(negedge clk);
    wrEn = 1'b1; addr = 5'h10; wrData = 32'h0000_0001; evDone = 8'h01;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; evDone = '0;
    rd(5'h10, v); check("R6 event beats clear", v, 32'h0000_0001);
    wr(5'h10, 32'h0000_0001);
    rd(5'h10, v); check("R7 clear after collision", v, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    check("R9 no start from reserved", chStart, 8'h00);
    rd(5'h0C, v); check("R9 0x0C zero", v, 32'h0);
    rd(5'h18, v); check("R9 0x18 zero", v, 32'h0);
    rd(5'h1C, v); check("R9 0x1C zero", v, 32'h0);
    rd(5'h00, v); check("R9 mode untouched", v, 32'h0000_0016);
    rd(5'h04, v); check("R9 aux untouched", v, 32'hA5C3_0F1E);
    rd(5'h08, v); check("R9 ctl untouched", v, 32'h0000_0020);
    check("R9 irq untouched", irq, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_mode();
    t_aux();
    t_start();
    t_busy();
    t_status();
    t_irq();
    t_collision();
    t_reserved();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule